// File: doc/BRIEF.md
# Lockable Multi-Bit Control Register with Encoding Checker

This block keeps a 16-bit configuration word built from four 4-bit redundant boolean fields: module enable, boot-request mode, auto-request mode and command-queue clear. Each field is legal only when it holds the true pattern 0x6 or the false pattern 0x9. Any other value is a sign of corruption or a software mistake. It is recorded in a sticky alert status register and announced by a one-cycle recoverable-alert pulse. The block decodes each field into one registered single-bit output, and an illegal field reads as false.

A one-way lock bit protects the configuration. It comes out of reset set. Software clears it by writing a zero, after which the control word can no longer change until the next reset. Software reaches the three registers through a plain word-addressed port with an address, write data, a write strobe and registered read data. Lock is at address 0, control at address 1 and alert status at address 2.

Top module: `cfg_lock_guard`

## Requirements
- R1: After reset the lock bit reads 1, the control word reads 0x0000_9999, the alert status reads 0 and all four decoded outputs and the alert pulse are 0.
- R2: A write to address 0 with bit 0 equal to 0 clears the lock bit. A write with bit 0 equal to 1 leaves it unchanged, so once it is 0 it stays 0 until reset. The lock reads back in bit 0 of address 0.
- R3: While the lock bit is 0, writes to the control word (address 1) are ignored.
- R4: The control word at address 1 holds enable in bits 3:0, boot mode in bits 7:4, auto mode in bits 11:8 and queue clear in bits 15:12. Bits 31:16 read 0. Read data appears on the clock edge that samples the address and shows the registers as they were before that edge.
- R5: Each decoded output is 1 exactly when its field equals 0x6. An illegal value or 0x9 gives 0. The output follows the control word with one cycle of delay.
- R6: A field holding anything other than 0x6 or 0x9 sets its status bit at address 2, one cycle after the field takes that value: bit 0 enable, bit 1 boot mode, bit 2 auto mode, bit 3 queue clear.
- R7: Status bits are sticky. A write to address 2 clears each bit whose write-data bit is 0 and keeps each bit whose write-data bit is 1. Bits 31:4 read 0.
- R8: When a clear and a detection hit the same status bit in the same cycle, the detection wins. A field that stays illegal keeps its bit set through a clear.
- R9: The alert pulse is high for one cycle, in the same cycle a status bit first shows 1 after having been 0. A bit that is already set raises no pulse.
- R10: Reads of any other address return 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (4) | Word address of the register access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | DATA_W (32) | Registered read data |
| en_o | output | 1 | Decoded enable field |
| boot_req_o | output | 1 | Decoded boot-request mode field |
| auto_req_o | output | 1 | Decoded auto-request mode field |
| fifo_clr_o | output | 1 | Decoded command-queue clear field |
| alert_pulse_o | output | 1 | One-cycle recoverable-alert pulse |

## Verification
The software clear of a status bit and the hardware detection of an illegal field can land on the same clock edge. The bench provokes this by leaving the auto-mode field at an illegal value and then writing zeros to the status register. It expects the bit to stay set and no new alert pulse to fire. A behavioural model tracks every register and output and is compared with the design on each cycle, so the readback, decoded outputs and pulse are judged on the exact cycle the overlap resolves.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  // Which register a bus access selects.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LOCK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STS  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cfg_lock_bit.sv
module cfg_lock_bit (
  input  logic clk,
  input  logic rst,
  input  logic clr_req_i,
  output logic lock_o
);
  always_ff @(posedge clk) begin
    if (rst)            lock_o <= 1'b1;
    else if (clr_req_i) lock_o <= 1'b0;
  end

  // R2
  lock_one_way_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_o |=> !lock_o);
endmodule

// File: rtl/mubi_field_chk.sv
module mubi_field_chk #(
  parameter int unsigned        FIELD_W   = 4,
  parameter logic [FIELD_W-1:0] TRUE_VAL  = 4'h6,
  parameter logic [FIELD_W-1:0] FALSE_VAL = 4'h9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] field_i,
  output logic               illegal_o,
  output logic               bit_o
);
  assign illegal_o = (field_i != TRUE_VAL) && (field_i != FALSE_VAL);

  always_ff @(posedge clk) begin
    if (rst) bit_o <= 1'b0;
    else     bit_o <= (field_i == TRUE_VAL);
  end

  // R5
  illegal_reads_false_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> !bit_o);
  // R5
  true_reads_one_chk: assert property (@(posedge clk) disable iff (rst)
    (field_i == TRUE_VAL) |=> bit_o);
endmodule

// File: rtl/alert_sts_reg.sv
module alert_sts_reg #(
  parameter int unsigned NUM = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] illegal_i,
  input  logic           wr_i,
  input  logic [NUM-1:0] keep_i,
  output logic [NUM-1:0] sts_o,
  output logic           pulse_o
);
  logic [NUM-1:0] after_clr;
  logic [NUM-1:0] sts_d;

  // Clear first, then OR in detection, so detection wins in a tie.
  assign after_clr = wr_i ? (sts_o & keep_i) : sts_o;
  assign sts_d     = after_clr | illegal_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_o   <= '0;
      pulse_o <= 1'b0;
    end else begin
      sts_o   <= sts_d;
      pulse_o <= |(sts_d & ~sts_o);
    end
  end

  // R7
  sts_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> ((sts_o & $past(sts_o)) == $past(sts_o)));
  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> (|(sts_o & ~$past(sts_o))));
  // R8
  detect_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|illegal_i) |=> ((sts_o & $past(illegal_i)) == $past(illegal_i)));
endmodule

// File: rtl/cfg_lock_guard.sv
module cfg_lock_guard #(
  parameter int unsigned        ADDR_W     = 4,
  parameter int unsigned        DATA_W     = 32,
  parameter int unsigned        FIELD_W    = 4,
  parameter int unsigned        NUM_FIELDS = 4,
  parameter logic [FIELD_W-1:0] TRUE_VAL   = 4'h6,
  parameter logic [FIELD_W-1:0] FALSE_VAL  = 4'h9,
  parameter logic [ADDR_W-1:0]  LOCK_ADDR  = 4'h0,
  parameter logic [ADDR_W-1:0]  CTRL_ADDR  = 4'h1,
  parameter logic [ADDR_W-1:0]  STS_ADDR   = 4'h2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              en_o,
  output logic              boot_req_o,
  output logic              auto_req_o,
  output logic              fifo_clr_o,
  output logic              alert_pulse_o
);
  import cfg_lock_pkg::*;

  localparam int unsigned CTRL_W = FIELD_W * NUM_FIELDS;
  localparam logic [CTRL_W-1:0] CTRL_RST = {NUM_FIELDS{FALSE_VAL}};

  reg_sel_e              sel;
  logic                  lock_q;
  logic [CTRL_W-1:0]     ctrl_q;
  logic [NUM_FIELDS-1:0] illegal;
  logic [NUM_FIELDS-1:0] field_bits;
  logic [NUM_FIELDS-1:0] sts_q;
  logic [DATA_W-1:0]     rdata_d;
  logic                  unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CTRL_W];

  // Address decode
  always_comb begin
    if      (reg_addr == LOCK_ADDR) sel = SEL_LOCK;
    else if (reg_addr == CTRL_ADDR) sel = SEL_CTRL;
    else if (reg_addr == STS_ADDR)  sel = SEL_STS;
    else                            sel = SEL_NONE;
  end

  cfg_lock_bit u_lock (
    .clk       (clk),
    .rst       (rst),
    .clr_req_i (reg_we && (sel == SEL_LOCK) && !reg_wdata[0]),
    .lock_o    (lock_q)
  );

  // Control word, writable only while unlocked
  always_ff @(posedge clk) begin
    if (rst)                                      ctrl_q <= CTRL_RST;
    else if (reg_we && (sel == SEL_CTRL) && lock_q) ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  // One checker/decoder per field
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    mubi_field_chk #(
      .FIELD_W   (FIELD_W),
      .TRUE_VAL  (TRUE_VAL),
      .FALSE_VAL (FALSE_VAL)
    ) u_chk (
      .clk       (clk),
      .rst       (rst),
      .field_i   (ctrl_q[g*FIELD_W +: FIELD_W]),
      .illegal_o (illegal[g]),
      .bit_o     (field_bits[g])
    );
  end

  alert_sts_reg #(.NUM(NUM_FIELDS)) u_sts (
    .clk     (clk),
    .rst     (rst),
    .illegal_i (illegal),
    .wr_i    (reg_we && (sel == SEL_STS)),
    .keep_i  (reg_wdata[NUM_FIELDS-1:0]),
    .sts_o   (sts_q),
    .pulse_o (alert_pulse_o)
  );

  assign en_o       = field_bits[0];
  assign boot_req_o = field_bits[1];
  assign auto_req_o = field_bits[2];
  assign fifo_clr_o = field_bits[3];

  // Readback
  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_LOCK: rdata_d[0]                = lock_q;
      SEL_CTRL: rdata_d[CTRL_W-1:0]       = ctrl_q;
      SEL_STS:  rdata_d[NUM_FIELDS-1:0]   = sts_q;
      default:  rdata_d                   = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rdata_d;
  end

  // R3
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_q |=> $stable(ctrl_q));
  // R4
  rdata_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:CTRL_W] == '0);
endmodule

// File: tb/cfg_lock_guard_bench.sv
module cfg_lock_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        en_o, boot_req_o, auto_req_o, fifo_clr_o, alert_pulse_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_lock_guard u_cfg_lock_guard (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .en_o(en_o),
    .boot_req_o(boot_req_o), .auto_req_o(auto_req_o),
    .fifo_clr_o(fifo_clr_o), .alert_pulse_o(alert_pulse_o)
  );

  // Behavioural reference model
  bit          m_lock;
  logic [15:0] m_ctrl;
  logic [3:0]  m_sts;
  logic [3:0]  m_out;
  bit          m_pulse;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    logic [3:0] bad;
    logic [3:0] nsts;
    logic [3:0] f;
    if (rst) begin
      m_lock = 1; m_ctrl = 16'h9999; m_sts = 0; m_out = 0; m_pulse = 0; m_rdata = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        f = m_ctrl[i*4 +: 4];
        bad[i] = (f != 4'h6) && (f != 4'h9);
        m_out[i] = (f == 4'h6);
      end
      nsts = (reg_we && reg_addr == 4'd2) ? (m_sts & reg_wdata[3:0]) : m_sts;
      nsts = nsts | bad;
      m_pulse = |(nsts & ~m_sts);
      case (reg_addr)
        4'd0: m_rdata = {31'd0, m_lock};
        4'd1: m_rdata = {16'd0, m_ctrl};
        4'd2: m_rdata = {28'd0, m_sts};
        default: m_rdata = 0;
      endcase
      if (reg_we && reg_addr == 4'd1 && m_lock) m_ctrl = reg_wdata[15:0];
      if (reg_we && reg_addr == 4'd0 && !reg_wdata[0]) m_lock = 0;
      m_sts = nsts;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4 rdata vs model", reg_rdata, m_rdata);
      check("R5 decoded outputs vs model", {28'd0, fifo_clr_o, auto_req_o, boot_req_o, en_o}, {28'd0, m_out});
      check("R9 alert pulse vs model", {31'd0, alert_pulse_o}, {31'd0, m_pulse});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check("R1 outputs after reset", {27'd0, alert_pulse_o, fifo_clr_o, auto_req_o, boot_req_o, en_o}, 32'd0);
    rd(4'd0, 32'd1, "R1 lock reset");
    rd(4'd1, 32'h9999, "R1 ctrl reset");
    rd(4'd2, 32'd0, "R1 status reset");
    // R4 layout and reserved bits, R5 decode
    wr(4'd1, 32'hFFFF_9696);
    idle(1);
    check("R5 en_o true field", {31'd0, en_o}, 32'd1);
    check("R5 boot_req_o false field", {31'd0, boot_req_o}, 32'd0);
    check("R5 auto_req_o true field", {31'd0, auto_req_o}, 32'd1);
    rd(4'd1, 32'h0000_9696, "R4 ctrl readback");
    // R6 illegal auto-mode field
    wr(4'd1, 32'h0000_9A96);
    idle(1);
    check("R5 illegal field reads false", {31'd0, auto_req_o}, 32'd0);
    rd(4'd2, 32'h4, "R6 auto field alert bit 2");
    // R8 clear while still illegal
    wr(4'd2, 32'h0);
    rd(4'd2, 32'h4, "R8 detect beats clear");
    // R7 write-one keeps, write-zero clears once legal
    wr(4'd1, 32'h0000_9996);
    idle(1);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, 32'h4, "R7 write one keeps bit");
    wr(4'd2, 32'hFFFF_FFFB);
    rd(4'd2, 32'h0, "R7 write zero clears bit");
    // R6 all fields illegal
    wr(4'd1, 32'h0000_3210);
    idle(1);
    rd(4'd2, 32'hF, "R6 every field alert");
    wr(4'd2, 32'hE);
    rd(4'd2, 32'hF, "R8 bit 0 held by detection");
    // R10 unmapped address
    wr(4'd1, 32'h0000_6969);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd7, 32'h0, "R10 unmapped read zero");
    rd(4'd1, 32'h6969, "R10 unmapped write no effect");
    wr(4'd2, 32'h0);
    rd(4'd2, 32'h0, "R7 clear all after legal");
    // R2 lock behaviour
    wr(4'd0, 32'h1);
    rd(4'd0, 32'h1, "R2 write one keeps lock");
    wr(4'd0, 32'hFFFF_FFFE);
    rd(4'd0, 32'h0, "R2 write zero clears lock");
    wr(4'd0, 32'h1);
    rd(4'd0, 32'h0, "R2 lock stays clear");
    // R3 writes ignored while locked
    wr(4'd1, 32'h0000_6666);
    idle(1);
    rd(4'd1, 32'h6969, "R3 ctrl frozen");
    check("R3 en_o unchanged", {31'd0, en_o}, 32'd0);
    idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule